// File: doc/BRIEF.md
# Register access command parser

This block is the slave-side command interpreter for a compact binary master/slave link. Bytes that arrive already framed on an input stream are decoded as commands. A data command reads or writes one, two, four or eight bytes of an internal byte-addressed register space through a simple memory port. The access starts either at an explicit 16-bit address carried in the command or at a persistent address pointer. The pointer can optionally be moved forward by the transfer size when the command finishes.

Local commands work on the parser itself. They return an identification cookie, read or set the pointer, add an offset to it, read or clear a sticky error status byte, and reset the parser. A stored-macro call is only recognised: the block raises a one-cycle flag with the macro number. Read data and local read results leave on an output byte stream in ascending address order. CRC generation and framing are handled outside the block, and a packet-start strobe abandons any half-received command.

Top module: `regacc_parser`

## Requirements
- R1: The header type sits in bits [7:6]. 01 is a data command. 10 is a macro call, which pulses `macro_go` for the accept cycle with `macro_num` = bits [5:0] and produces no output bytes. 11 is a local command. A 00 header is consumed with no effect, and the next byte is read as a new header.
- R2: In a data header, bit 5 = 1 selects write and 0 selects read. Bits [1:0] give the size: 00 → 1 byte, 01 → 2, 10 → 4, 11 → 8. Writes take that many data bytes from the input stream.
- R3: When header bit 2 is 1, an address follows as a low byte and then a high byte, and it loads the pointer. When bit 2 is 0, the current pointer is used. Byte k of a transfer goes to pointer + k.
- R4: When header bit 3 is 1, the pointer ends the command advanced by the size. Otherwise it keeps the start address.
- R5: Read data leaves on the output stream in ascending address order, one byte per `out_valid`/`out_ready` handshake. `in_ready` is low while a reply byte is pending.
- R6: A write to an address inside [PROT_LO, PROT_HI] (default 0x0000–0x003F) is dropped and sets status bit 5. The transfer still steps through its addresses.
- R7: Local reads return one byte: 0xDF → the cookie 0x5A, 0xD8/0xD9 → the pointer's low/high byte, 0xC1 → the status byte. Any other header from 0xC0 to 0xDF returns 0x00.
- R8: Local writes 0xE0–0xFE take one data byte. 0xF8 and 0xF9 replace the pointer's low and high byte, and 0xFA adds the byte to the pointer modulo 2^16. Other codes in this range have no effect.
- R9: 0xE1 with data 0x00 clears the status byte, and a nonzero data byte leaves it unchanged. An error event in the same cycle as the clear stays set.
- R10: Status bits are sticky. `err_evt[0]` sets bit 0 (CRC), `[1]` sets bit 3 (watchdog), `[2]` sets bit 4 (overflow) and `[3]` sets bit 6 (timeout).
- R11: Header 0xFF takes no data byte, and the next byte is read as a header.
- R12: `pkt_start` returns the parser to header wait. A partially received address does not reach the pointer. While `pkt_start` is high, `in_ready` and `out_valid` are low.
- R13: After reset the pointer and status are zero, `in_ready` is high, and `out_valid`, `mem_we` and `macro_go` are low.
- R14: While `out_valid` is high and `out_ready` is low, the output byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Packet start / abort strobe |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Reply byte taken when high with out_valid |
| out_data | output | 8 | Reply byte |
| mem_we | output | 1 | Register space write strobe |
| mem_re | output | 1 | Register space read enable |
| mem_addr | output | 16 | Register space byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, combinational from mem_addr |
| err_evt | input | 4 | Error events: CRC, watchdog, overflow, timeout |
| macro_go | output | 1 | Macro call recognised |
| macro_num | output | 6 | Macro number |

## Verification
Two collisions matter most. The first is a status clear by 0xE1 landing in the same cycle as an external error event. The bench raises `err_evt[0]` on the very cycle the 0x00 data byte is accepted, then reads 0xC1 and expects bit 0 still set. The second is `pkt_start` arriving while a byte is being offered. The bench drives both together after a partial addressed command, checks that `in_ready` is low, and then expects the held byte to be decoded as a fresh header, with the pointer untouched by the abandoned address.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  localparam int PTR_W = 16;

  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_DATA  = 2'b01,
    K_MACRO = 2'b10,
    K_LOCAL = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    ST_HDR, ST_ALO, ST_AHI, ST_XFER, ST_LWR, ST_LRD
  } pstate_e;

  typedef struct packed {
    kind_e      kind;
    logic       wr;
    logic       inc;
    logic       addr;
    logic [3:0] nbytes;
  } hdr_t;

  // local command codes
  localparam logic [7:0] OP_STATUS_RD  = 8'hC1;
  localparam logic [7:0] OP_PTRLO_RD   = 8'hD8;
  localparam logic [7:0] OP_PTRHI_RD   = 8'hD9;
  localparam logic [7:0] OP_COOKIE_RD  = 8'hDF;
  localparam logic [7:0] OP_STATUS_WR  = 8'hE1;
  localparam logic [7:0] OP_PTRLO_WR   = 8'hF8;
  localparam logic [7:0] OP_PTRHI_WR   = 8'hF9;
  localparam logic [7:0] OP_PTRADD_WR  = 8'hFA;
  localparam logic [7:0] OP_PARSER_RST = 8'hFF;

  // status bit positions
  localparam int SB_CRC  = 0;
  localparam int SB_WDOG = 3;
  localparam int SB_OVF  = 4;
  localparam int SB_PROT = 5;
  localparam int SB_TMO  = 6;

  function automatic logic [3:0] size_of(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_plus(input logic [PTR_W-1:0] p,
                                                input logic [7:0] d);
    return p + {{(PTR_W-8){1'b0}}, d};
  endfunction

  function automatic logic in_window(input logic [PTR_W-1:0] a,
                                     input logic [PTR_W-1:0] lo,
                                     input logic [PTR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/regacc_hdr_dec.sv
module regacc_hdr_dec
  import regacc_pkg::*;
(
  input  logic [7:0] hb_i,
  output hdr_t       hdr_o,
  output logic       lcl_wr_o,
  output logic       lcl_nodata_o
);

  always_comb begin
    hdr_o.kind   = kind_e'(hb_i[7:6]);
    hdr_o.wr     = hb_i[5];
    hdr_o.inc    = hb_i[3];
    hdr_o.addr   = hb_i[2];
    hdr_o.nbytes = size_of(hb_i[1:0]);
  end

  // local codes with bit 5 set carry one data byte, except the parser reset
  assign lcl_wr_o     = hb_i[5];
  assign lcl_nodata_o = (hb_i == OP_PARSER_RST);

endmodule

// File: rtl/regacc_ptr.sv
module regacc_ptr
  import regacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             lo_en,
  input  logic             hi_en,
  input  logic             add_en,
  input  logic             adv_en,
  input  logic [7:0]       byte_i,
  input  logic [3:0]       adv_i,
  output logic [PTR_W-1:0] ptr_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_o <= '0;
    else if (ld_en)   ptr_o <= ld_val;
    else if (lo_en)   ptr_o[7:0] <= byte_i;
    else if (hi_en)   ptr_o[PTR_W-1:8] <= byte_i;
    else if (add_en)  ptr_o <= ptr_plus(ptr_o, byte_i);
    else if (adv_en)  ptr_o <= ptr_o + {{(PTR_W-4){1'b0}}, adv_i};
  end

endmodule

// File: rtl/regacc_status.sv
module regacc_status
  import regacc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] evt_i,
  input  logic       prot_i,
  input  logic       clr_i,
  output logic [7:0] stat_o
);

  logic [7:0] set_v;

  always_comb begin
    set_v          = '0;
    set_v[SB_CRC]  = evt_i[0];
    set_v[SB_WDOG] = evt_i[1];
    set_v[SB_OVF]  = evt_i[2];
    set_v[SB_TMO]  = evt_i[3];
    set_v[SB_PROT] = prot_i;
  end

  // new events win over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= (clr_i ? 8'h00 : stat_o) | set_v;
  end

endmodule

// File: rtl/regacc_parser.sv
module regacc_parser
  import regacc_pkg::*;
#(
  parameter logic [15:0] PROT_LO = 16'h0000,
  parameter logic [15:0] PROT_HI = 16'h003F,
  parameter logic [7:0]  COOKIE  = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             mem_we,
  output logic             mem_re,
  output logic [PTR_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic [3:0]       err_evt,
  output logic             macro_go,
  output logic [5:0]       macro_num
);

  pstate_e          st_q, st_d;
  hdr_t             hdr_in;
  logic             lcl_wr, lcl_nodata;
  logic             wr_q, inc_q;
  logic [3:0]       nb_q, idx_q;
  logic [7:0]       lo_q, lop_q, lrd_q;
  logic [PTR_W-1:0] ptr, xfer_addr;
  logic [7:0]       status;

  // named internal events
  logic in_fire, out_fire, hdr_acc, rd_phase, wr_phase, beat, last_beat;
  logic prot_hit, prot_err, lwr_fire, stat_clr;
  logic ptr_ld, ptr_lo, ptr_hi, ptr_add, ptr_adv;

  function automatic logic [7:0] lrd_value(input logic [7:0] op,
                                           input logic [PTR_W-1:0] p,
                                           input logic [7:0] st);
    case (op)
      OP_COOKIE_RD: return COOKIE;
      OP_PTRLO_RD:  return p[7:0];
      OP_PTRHI_RD:  return p[15:8];
      OP_STATUS_RD: return st;
      default:      return 8'h00;
    endcase
  endfunction

  regacc_hdr_dec u_dec (
    .hb_i(in_data), .hdr_o(hdr_in),
    .lcl_wr_o(lcl_wr), .lcl_nodata_o(lcl_nodata)
  );

  assign rd_phase  = (st_q == ST_XFER) && !wr_q;
  assign wr_phase  = (st_q == ST_XFER) && wr_q;
  assign out_valid = !pkt_start && (rd_phase || st_q == ST_LRD);
  assign in_ready  = !pkt_start && !(rd_phase || st_q == ST_LRD);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign hdr_acc   = (st_q == ST_HDR) && in_fire;
  assign lwr_fire  = (st_q == ST_LWR) && in_fire;

  assign xfer_addr = ptr + {{(PTR_W-4){1'b0}}, idx_q};
  assign last_beat = (idx_q == nb_q - 4'd1);
  assign beat      = wr_phase ? in_fire : (rd_phase && out_fire);
  assign prot_hit  = in_window(xfer_addr, PROT_LO, PROT_HI);

  assign mem_we    = wr_phase && in_fire && !prot_hit;
  assign prot_err  = wr_phase && in_fire && prot_hit;
  assign mem_re    = rd_phase && !pkt_start;
  assign mem_addr  = xfer_addr;
  assign mem_wdata = in_data;
  assign out_data  = (st_q == ST_LRD) ? lrd_q : mem_rdata;

  assign macro_go  = hdr_acc && (hdr_in.kind == K_MACRO);
  assign macro_num = in_data[5:0];

  assign stat_clr  = lwr_fire && (lop_q == OP_STATUS_WR) && (in_data == 8'h00);
  assign ptr_ld    = (st_q == ST_AHI) && in_fire;
  assign ptr_lo    = lwr_fire && (lop_q == OP_PTRLO_WR);
  assign ptr_hi    = lwr_fire && (lop_q == OP_PTRHI_WR);
  assign ptr_add   = lwr_fire && (lop_q == OP_PTRADD_WR);
  assign ptr_adv   = beat && last_beat && inc_q;

  regacc_ptr u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ptr_ld), .ld_val({in_data, lo_q}),
    .lo_en(ptr_lo), .hi_en(ptr_hi), .add_en(ptr_add), .adv_en(ptr_adv),
    .byte_i(in_data), .adv_i(nb_q), .ptr_o(ptr)
  );

  regacc_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(err_evt),
    .prot_i(prot_err), .clr_i(stat_clr), .stat_o(status)
  );

  always_comb begin
    st_d = st_q;
    if (pkt_start) st_d = ST_HDR;
    else begin
      case (st_q)
        ST_HDR: if (in_fire) begin
          case (hdr_in.kind)
            K_DATA:  st_d = hdr_in.addr ? ST_ALO : ST_XFER;
            K_LOCAL: if (!lcl_nodata) st_d = lcl_wr ? ST_LWR : ST_LRD;
            default: st_d = ST_HDR;
          endcase
        end
        ST_ALO:  if (in_fire) st_d = ST_AHI;
        ST_AHI:  if (in_fire) st_d = ST_XFER;
        ST_XFER: if (beat && last_beat) st_d = ST_HDR;
        ST_LWR:  if (in_fire) st_d = ST_HDR;
        ST_LRD:  if (out_fire) st_d = ST_HDR;
        default: st_d = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_HDR;
      wr_q  <= 1'b0;
      inc_q <= 1'b0;
      nb_q  <= 4'd1;
      idx_q <= '0;
      lo_q  <= '0;
      lop_q <= '0;
      lrd_q <= '0;
    end else begin
      st_q <= st_d;
      if (hdr_acc) begin
        wr_q  <= hdr_in.wr;
        inc_q <= hdr_in.inc;
        nb_q  <= hdr_in.nbytes;
        lop_q <= in_data;
        lrd_q <= lrd_value(in_data, ptr, status);
      end
      if (pkt_start || hdr_acc)   idx_q <= '0;
      else if (beat && !last_beat) idx_q <= idx_q + 4'd1;
      if ((st_q == ST_ALO) && in_fire) lo_q <= in_data;
    end
  end

endmodule

// File: rtl/regacc_parser_chk.sv
module regacc_parser_chk
  import regacc_pkg::*;
#(
  parameter logic [15:0] PROT_LO = 16'h0000,
  parameter logic [15:0] PROT_HI = 16'h003F
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_start,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             mem_we,
  input logic             mem_re,
  input logic [PTR_W-1:0] mem_addr,
  input logic             macro_go,
  input logic [3:0]       err_evt,
  input logic             prot_err,
  input logic [6:3]       stat_hi,
  input logic             stat_crc
);

  a_r5_no_accept_during_reply: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r14_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (pkt_start || (out_valid && $stable(out_data))));

  a_r12_start_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (!in_ready && !out_valid));

  a_r6_protected_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !in_window(mem_addr, PROT_LO, PROT_HI));

  a_r6_prot_flag: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> stat_hi[5]);

  a_r10_crc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[0] |=> stat_crc);

  a_r10_wdog_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[1] |=> stat_hi[3]);

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[2] |=> stat_hi[4]);

  a_r10_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[3] |=> stat_hi[6]);

  a_r1_macro_silent: assert property (@(posedge clk) disable iff (!rst_n)
    macro_go |-> (!out_valid && !mem_we && !mem_re));

  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_re);

endmodule

bind regacc_parser regacc_parser_chk #(.PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .macro_go(macro_go),
  .err_evt(err_evt), .prot_err(prot_err),
  .stat_hi(status[6:3]), .stat_crc(status[0])
);

// File: tb/regacc_parser_test.sv
module regacc_parser_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, pkt_start, in_valid, out_ready;
  logic [7:0]  in_data;
  logic [3:0]  err_evt;
  wire         in_ready, out_valid, mem_we, mem_re, macro_go;
  wire  [7:0]  out_data, mem_wdata;
  wire  [15:0] mem_addr;
  wire  [5:0]  macro_num;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem [1024];

  int checks = 0;
  int errors = 0;
  logic [7:0] got [16];
  int ng = 0;
  int mcount = 0;
  int mlast = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regacc_parser uut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .err_evt(err_evt), .macro_go(macro_go), .macro_num(macro_num)
  );

  // register space model: initial content addr ^ 0xA5
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_addr[9:0]];

  // reply and macro monitor
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && ng < 16) begin
      got[ng] = out_data;
      ng++;
    end
    if (rst_n && macro_go) begin
      mcount++;
      mlast = int'(macro_num);
    end
  end

  typedef struct packed {
    logic [3:0]  nin;
    logic [63:0] din;
    logic [3:0]  nout;
    logic [63:0] dout;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 64'hD8D9_0000_0000_0000, 4'd2, 64'h0000_0000_0000_0000, 8'd13}, // R13 pointer 0
    '{4'd1, 64'hDF00_0000_0000_0000, 4'd1, 64'h5A00_0000_0000_0000, 8'd7},  // R7 cookie
    '{4'd7, 64'h6E00_01AA_BBCC_DD00, 4'd0, 64'h0,                   8'd3},  // R3 write 4 @0x100 inc
    '{4'd2, 64'hD8D9_0000_0000_0000, 4'd2, 64'h0401_0000_0000_0000, 8'd4},  // R4 ptr 0x104
    '{4'd3, 64'h61EE_FF00_0000_0000, 4'd0, 64'h0,                   8'd2},  // R2 write 2 at ptr
    '{4'd2, 64'hD8D9_0000_0000_0000, 4'd2, 64'h0401_0000_0000_0000, 8'd4},  // R4 no inc
    '{4'd3, 64'h4700_0100_0000_0000, 4'd8, 64'hAABB_CCDD_EEFF_A3A2, 8'd5},  // R5 read 8
    '{4'd2, 64'hD8D9_0000_0000_0000, 4'd2, 64'h0001_0000_0000_0000, 8'd3},  // R3 addr loads ptr
    '{4'd8, 64'hF830_F902_FA10_D8D9, 4'd2, 64'h4002_0000_0000_0000, 8'd8},  // R8 set/add
    '{4'd2, 64'h48D8_0000_0000_0000, 4'd2, 64'hE541_0000_0000_0000, 8'd4},  // R4 read 1 inc
    '{4'd2, 64'h41D8_0000_0000_0000, 4'd3, 64'hE4E7_4100_0000_0000, 8'd2},  // R2 read 2
    '{4'd5, 64'h6410_0077_C100_0000, 4'd1, 64'h2000_0000_0000_0000, 8'd6},  // R6 prot write
    '{4'd6, 64'h4410_00E1_00C1_0000, 4'd2, 64'hB500_0000_0000_0000, 8'd9},  // R9 clear
    '{4'd2, 64'h85DF_0000_0000_0000, 4'd1, 64'h5A00_0000_0000_0000, 8'd1},  // R1 macro silent
    '{4'd3, 64'h003F_DF00_0000_0000, 4'd1, 64'h5A00_0000_0000_0000, 8'd1},  // R1 type 00
    '{4'd2, 64'hFFDF_0000_0000_0000, 4'd1, 64'h5A00_0000_0000_0000, 8'd11}, // R11
    '{4'd8, 64'hF8FF_F9FF_FA02_D8D9, 4'd2, 64'h0100_0000_0000_0000, 8'd8},  // R8 wrap
    '{4'd2, 64'hC5D0_0000_0000_0000, 4'd2, 64'h0000_0000_0000_0000, 8'd7},  // R7 other codes
    '{4'd3, 64'h4F20_0100_0000_0000, 4'd8, 64'h8584_8786_8180_8382, 8'd5},  // R5 read 8 inc
    '{4'd2, 64'hD8D9_0000_0000_0000, 4'd2, 64'h2801_0000_0000_0000, 8'd4},  // R4 +8
    '{4'd7, 64'h6630_0211_2233_4400, 4'd0, 64'h0,                   8'd3},  // R3 write 4 no inc
    '{4'd1, 64'h4200_0000_0000_0000, 4'd4, 64'h1122_3344_0000_0000, 8'd2}   // R2 read 4
  };

  task automatic check(input logic ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic [3:0] ev);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    err_evt  = ev;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    err_evt  = 4'h0;
  endtask

  task automatic expect_reply(input int ne, input logic [63:0] dexp, input string tag);
    logic ok;
    logic [63:0] act;
    repeat (12) @(negedge clk);
    ok  = (ng == ne);
    act = '0;
    for (int k = 0; k < 8; k++) begin
      if (k < ng) act[63-8*k -: 8] = got[k];
      if (k < ne && (k >= ng || got[k] != dexp[63-8*k -: 8])) ok = 1'b0;
    end
    check(ok, tag, $sformatf("reply got %0d bytes %h, expected %0d bytes %h",
                             ng, act, ne, dexp));
  endtask

  task automatic xact(input int nin, input logic [63:0] din, input int ne,
                      input logic [63:0] dexp, input string tag);
    ng = 0;
    for (int k = 0; k < nin; k++) send_byte(din[63-8*k -: 8], 4'h0);
    expect_reply(ne, dexp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pkt_start = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    err_evt = 4'h0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state at the ports
    check(in_ready && !out_valid && !mem_we && !macro_go, "R13",
          $sformatf("rdy=%b vld=%b we=%b mg=%b expected 1 0 0 0",
                    in_ready, out_valid, mem_we, macro_go));

    for (int v = 0; v < NV; v++)
      xact(int'(VEC[v].nin), VEC[v].din, int'(VEC[v].nout), VEC[v].dout,
           $sformatf("R%0d vec%0d", VEC[v].tag, v));

    // R1 macro number observed once
    check(mcount == 1 && mlast == 5, "R1",
          $sformatf("macro pulses %0d num %0d, expected 1 and 5", mcount, mlast));

    // R10 event mapping
    @(negedge clk); err_evt = 4'hF;
    @(negedge clk); err_evt = 4'h0;
    xact(1, 64'hC100_0000_0000_0000, 1, 64'h5900_0000_0000_0000, "R10 map");

    // R9 clear collides with event: event wins
    ng = 0;
    send_byte(8'hE1, 4'h0);
    send_byte(8'h00, 4'h1);
    xact(1, 64'hC100_0000_0000_0000, 1, 64'h0100_0000_0000_0000, "R9 collide");
    xact(3, 64'hE105_C100_0000_0000, 1, 64'h0100_0000_0000_0000, "R9 nonzero");
    xact(3, 64'hE100_C100_0000_0000, 1, 64'h0000_0000_0000_0000, "R9 clear");

    // R12 abort mid-address with a byte offered in the same cycle
    send_byte(8'h6E, 4'h0);
    send_byte(8'h00, 4'h0);
    ng = 0;
    @(negedge clk);
    pkt_start = 1'b1; in_valid = 1'b1; in_data = 8'hDF;
    #1;
    check(!in_ready, "R12", $sformatf("in_ready=%b during start, expected 0", in_ready));
    @(negedge clk);
    pkt_start = 1'b0;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    expect_reply(1, 64'h5A00_0000_0000_0000, "R12 header after abort");
    xact(2, 64'hD8D9_0000_0000_0000, 2, 64'h3002_0000_0000_0000, "R12 ptr kept");

    // R14 stall on output
    out_ready = 1'b0;
    ng = 0;
    send_byte(8'h42, 4'h0);
    repeat (4) @(negedge clk);
    check(out_valid && out_data == 8'h11 && !in_ready && ng == 0, "R14",
          $sformatf("vld=%b data=%h rdy=%b n=%0d expected 1 11 0 0",
                    out_valid, out_data, in_ready, ng));
    out_ready = 1'b1;
    expect_reply(4, 64'h1122_3344_0000_0000, "R14 after stall");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule